// File: doc/BRIEF.md
# DDS Tuning Word Load Interface

This block takes the frequency, phase and control settings of a direct digital synthesizer from a host processor. The host can send them in one of two ways. In byte mode it makes five writes on an 8-bit bus, each marked by a word-clock strobe. In bit mode it sends a 40-bit stream on one data line, one bit per word-clock strobe. The pieces collect in a 40-bit staging word. A separate commit strobe copies the whole staging word into the active register, which drives the synthesis core. The commit also returns the load position to the start, so a new word can be staged while the core keeps running on the old one.

The staging word has two parts. Bits [31:0] are the tuning word. Bits [39:32] are a control byte: a 5-bit phase offset, a power-down flag and two format bits. If a commit carries a control byte whose format bits are both set, the interface switches to bit mode and stays there until reset. Both strobes are level inputs. They are sampled on the system clock and acted on at their rising edges. The active-low reset clears the load position, the staging word, the active register and the mode.

Top module: `dds_word_loader`

## Requirements
- R1: While reset is asserted, and until the first commit after it, ftw_o, phase_o and pdown_o are 0 and upd_o is 0. After reset the interface is in byte mode.
- R2: In byte mode a full load is five word-clock rising edges. The 1st byte is the control byte. The 2nd byte is tuning bits [31:24], the 3rd is [23:16], the 4th is [15:8] and the 5th is [7:0].
- R3: The control byte is split as follows. Bits [7:3] are the phase word, bit 2 is the power-down flag and bits [1:0] are the format bits. phase_o and pdown_o show the committed values of those fields.
- R4: A rising edge on commit_i copies the staging word into the active register. At the clock edge that first samples commit_i high, ftw_o, phase_o and pdown_o take the staged values.
- R5: upd_o is high for exactly one clock cycle, the cycle right after a commit edge.
- R6: A commit returns the load position to the start. The next word-clock edge writes the control byte in byte mode, or staging bit 0 in bit mode. Staging bits that are not rewritten keep their earlier values.
- R7: In byte mode, word-clock edges after the fifth and before the next commit change nothing. The load position does not wrap.
- R8: A commit whose staged format bits are 2'b11 switches the interface to bit mode. Bit mode is kept through later commits, whatever format bits they carry, until reset.
- R9: In bit mode each word-clock edge stores data_i[7] into the staging word, low bit first. Tuning bit 0 comes first, tuning bit 31 is the 32nd and control bit 7 is the 40th.
- R10: In bit mode, word-clock edges after the fortieth bit and before the next commit change nothing.
- R11: The active outputs stay unchanged between commits, however much word-clock traffic arrives.
- R12: A reset in the middle of a load clears the staging word and the load position. A commit with no writes after it gives all-zero outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; both strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low master reset |
| word_clk_i | input | 1 | Word-clock strobe; each rising edge stores one byte or one bit |
| commit_i | input | 1 | Commit strobe; a rising edge moves the staging word to the active register |
| data_i | input | 8 | Byte bus; bit 7 is the single-line input in bit mode |
| ftw_o | output | 32 | Active frequency tuning word |
| phase_o | output | 5 | Active phase word |
| pdown_o | output | 1 | Active power-down flag |
| upd_o | output | 1 | One-cycle pulse after each commit |

## Verification
A byte or bit is stored at the same clock edge that first samples word_clk_i high, so nothing can be seen at the outputs until the next commit. A commit updates ftw_o, phase_o and pdown_o, and raises upd_o, at the edge that first samples commit_i high. upd_o falls again one edge later. The bench drives each strobe high for exactly one cycle, starting at a falling edge. It reads the outputs at the falling edge right after the commit edge, which is when new values and upd_o must both be present. It reads again one falling edge later to confirm that upd_o has dropped and the values have held.

// File: rtl/dds_load_pkg.sv
`timescale 1ns/1ps
package dds_load_pkg;

   typedef enum logic {
      MODE_BYTE = 1'b0,
      MODE_BIT  = 1'b1
   } load_mode_e;

   localparam logic [1:0] FMT_TO_BIT = 2'b11;

   // lane (byte write index) that carries a given staging bit in byte mode
   function automatic int lane_of(input int bit_idx, input int ftw_w, input int bus_w);
      if (bit_idx >= ftw_w) return 0;
      return 1 + (ftw_w - 1 - bit_idx) / bus_w;
   endfunction

endpackage

// File: rtl/dds_edge_rise.sv
`timescale 1ns/1ps
module dds_edge_rise #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   output logic [W-1:0] rise_o
);

   for (genvar i = 0; i < W; i++) begin : g_ch
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl_i[i];
      end
      assign rise_o[i] = lvl_i[i] & ~prev_q;

      // a rising edge is never reported two cycles in a row
      p_single_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[i] |=> !rise_o[i]);
   end

endmodule

// File: rtl/dds_load_ptr.sv
`timescale 1ns/1ps
module dds_load_ptr
   import dds_load_pkg::*;
#(
   parameter int WORD_W  = 40,
   parameter int N_BYTES = 5,
   parameter int PTR_W   = $clog2(WORD_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_rise_i,
   input  logic             commit_rise_i,
   input  logic             go_bit_i,
   output logic [PTR_W-1:0] ptr_o,
   output load_mode_e       mode_o,
   output logic             wr_en_o
);

   localparam logic [PTR_W-1:0] BYTE_LIMIT = PTR_W'(N_BYTES);
   localparam logic [PTR_W-1:0] BIT_LIMIT  = PTR_W'(WORD_W);

   logic [PTR_W-1:0] ptr_q;
   load_mode_e       mode_q;
   logic             full;

   always_comb begin
      full = (mode_q == MODE_BYTE) ? (ptr_q == BYTE_LIMIT) : (ptr_q == BIT_LIMIT);
   end

   assign wr_en_o = wr_rise_i & ~commit_rise_i & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         mode_q <= MODE_BYTE;
      end else if (commit_rise_i) begin
         ptr_q <= '0;
         if (go_bit_i) mode_q <= MODE_BIT;
      end else if (wr_en_o) begin
         ptr_q <= ptr_q + 1'b1;
      end
   end

   assign ptr_o  = ptr_q;
   assign mode_o = mode_q;

   p_ptr_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_BYTE) ? (ptr_q <= BYTE_LIMIT) : (ptr_q <= BIT_LIMIT));

   p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_rise_i && !commit_rise_i) |=> (ptr_q == $past(ptr_q)));

   p_ptr_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_rise_i |=> (ptr_q == '0));

   p_mode_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_BIT) |=> (mode_q == MODE_BIT));

endmodule

// File: rtl/dds_stage_reg.sv
`timescale 1ns/1ps
module dds_stage_reg
   import dds_load_pkg::*;
#(
   parameter int FTW_W   = 32,
   parameter int BUS_W   = 8,
   parameter int WORD_W  = 40,
   parameter int PTR_W   = 6,
   parameter int SER_BIT = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  load_mode_e        mode_i,
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [BUS_W-1:0]  data_i,
   output logic [WORD_W-1:0] word_o
);

   for (genvar j = 0; j < WORD_W; j++) begin : g_bit
      localparam int LANE = lane_of(j, FTW_W, BUS_W);
      localparam int POS  = j % BUS_W;
      logic bit_q;
      logic byte_hit;
      logic line_hit;

      assign byte_hit = (mode_i == MODE_BYTE) && (ptr_i == PTR_W'(LANE));
      assign line_hit = (mode_i == MODE_BIT)  && (ptr_i == PTR_W'(j));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                    bit_q <= 1'b0;
         else if (wr_en_i && byte_hit)  bit_q <= data_i[POS];
         else if (wr_en_i && line_hit)  bit_q <= data_i[SER_BIT];
      end
      assign word_o[j] = bit_q;
   end

   p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |=> $stable(word_o));

endmodule

// File: rtl/dds_active_reg.sv
`timescale 1ns/1ps
module dds_active_reg #(
   parameter int FTW_W   = 32,
   parameter int BUS_W   = 8,
   parameter int PHASE_W = 5,
   parameter int WORD_W  = 40,
   parameter int PDN_BIT = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               commit_i,
   input  logic [WORD_W-1:0]  word_i,
   output logic [FTW_W-1:0]   ftw_o,
   output logic [PHASE_W-1:0] phase_o,
   output logic               pdown_o,
   output logic               upd_o
);

   logic [BUS_W-1:0] ctrl;
   assign ctrl = word_i[WORD_W-1:FTW_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ftw_o   <= '0;
         phase_o <= '0;
         pdown_o <= 1'b0;
         upd_o   <= 1'b0;
      end else begin
         upd_o <= commit_i;
         if (commit_i) begin
            ftw_o   <= word_i[FTW_W-1:0];
            phase_o <= ctrl[BUS_W-1 -: PHASE_W];
            pdown_o <= ctrl[PDN_BIT];
         end
      end
   end

   p_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i |=> (upd_o && ftw_o == $past(word_i[FTW_W-1:0])));

   p_upd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      upd_o |=> !upd_o);

   p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !commit_i |=> ($stable(ftw_o) && $stable(phase_o) && $stable(pdown_o)));

endmodule

// File: rtl/dds_word_loader.sv
`timescale 1ns/1ps
module dds_word_loader
   import dds_load_pkg::*;
#(
   parameter int FTW_W   = 32,
   parameter int BUS_W   = 8,
   parameter int PHASE_W = 5,
   parameter int SER_BIT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_clk_i,
   input  logic               commit_i,
   input  logic [BUS_W-1:0]   data_i,
   output logic [FTW_W-1:0]   ftw_o,
   output logic [PHASE_W-1:0] phase_o,
   output logic               pdown_o,
   output logic               upd_o
);

   localparam int WORD_W  = FTW_W + BUS_W;
   localparam int N_BYTES = WORD_W / BUS_W;
   localparam int PTR_W   = $clog2(WORD_W + 1);
   localparam int PDN_BIT = BUS_W - PHASE_W - 1;

   if (PHASE_W + 3 != BUS_W) begin : g_bad_ctrl
      $error("control byte must hold phase, power-down and two format bits");
   end
   if (FTW_W % BUS_W != 0) begin : g_bad_ftw
      $error("tuning word must be a whole number of bus bytes");
   end
   if (SER_BIT >= BUS_W) begin : g_bad_ser
      $error("single-line input must be a bus bit");
   end

   logic [1:0]        rise;
   logic [PTR_W-1:0]  ptr;
   load_mode_e        mode;
   logic              wr_en;
   logic [WORD_W-1:0] stage;
   logic              go_bit;

   dds_edge_rise #(.W(2)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  ({commit_i, word_clk_i}),
      .rise_o (rise)
   );

   assign go_bit = (stage[FTW_W +: 2] == FMT_TO_BIT);

   dds_load_ptr #(
      .WORD_W  (WORD_W),
      .N_BYTES (N_BYTES),
      .PTR_W   (PTR_W)
   ) u_ptr (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_rise_i     (rise[0]),
      .commit_rise_i (rise[1]),
      .go_bit_i      (go_bit),
      .ptr_o         (ptr),
      .mode_o        (mode),
      .wr_en_o       (wr_en)
   );

   dds_stage_reg #(
      .FTW_W   (FTW_W),
      .BUS_W   (BUS_W),
      .WORD_W  (WORD_W),
      .PTR_W   (PTR_W),
      .SER_BIT (SER_BIT)
   ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en),
      .mode_i  (mode),
      .ptr_i   (ptr),
      .data_i  (data_i),
      .word_o  (stage)
   );

   dds_active_reg #(
      .FTW_W   (FTW_W),
      .BUS_W   (BUS_W),
      .PHASE_W (PHASE_W),
      .WORD_W  (WORD_W),
      .PDN_BIT (PDN_BIT)
   ) u_active (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit_i (rise[1]),
      .word_i   (stage),
      .ftw_o    (ftw_o),
      .phase_o  (phase_o),
      .pdown_o  (pdown_o),
      .upd_o    (upd_o)
   );

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!upd_o && $stable(ftw_o)) || $past(commit_i) || upd_o || $stable(ftw_o));

endmodule

// File: tb/dds_word_loader_tb.sv
`timescale 1ns/1ps
module dds_word_loader_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wclk = 1'b0;
   logic        cmt = 1'b0;
   logic [7:0]  data = 8'h00;
   logic [31:0] ftw;
   logic [4:0]  phase;
   logic        pdown;
   logic        upd;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [39:0] m_stage;
   logic [39:0] m_act;
   int          m_ptr;
   bit          m_bitmode;

   always #2 clk = ~clk;

   dds_word_loader dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_clk_i (wclk),
      .commit_i   (cmt),
      .data_i     (data),
      .ftw_o      (ftw),
      .phase_o    (phase),
      .pdown_o    (pdown),
      .upd_o      (upd)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_stage = '0; m_act = '0; m_ptr = 0; m_bitmode = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0; wclk = 1'b0; cmt = 1'b0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic wr_byte(input logic [7:0] b);
      @(negedge clk); data = b; wclk = 1'b1;
      if (!m_bitmode && m_ptr < 5) begin
         if (m_ptr == 0) m_stage[39:32] = b;
         else            m_stage[31 - (m_ptr - 1) * 8 -: 8] = b;
         m_ptr++;
      end
      @(negedge clk); wclk = 1'b0;
   endtask

   task automatic wr_bit(input logic v);
      @(negedge clk); data = {v, 7'h55}; wclk = 1'b1;
      if (m_bitmode && m_ptr < 40) begin
         m_stage[m_ptr] = v;
         m_ptr++;
      end
      @(negedge clk); wclk = 1'b0;
   endtask

   task automatic send_bits(input logic [39:0] w, input int n);
      for (int i = 0; i < n; i++) wr_bit(w[i % 40]);
   endtask

   task automatic commit_chk(input string req);
      @(negedge clk); cmt = 1'b1;
      @(negedge clk); cmt = 1'b0;
      m_act = m_stage;
      if (m_stage[33:32] == 2'b11) m_bitmode = 1'b1;
      m_ptr = 0;
      chk(ftw == m_act[31:0], {req, " ftw"}, 64'(ftw), 64'(m_act[31:0]));
      chk(phase == m_act[39:35] && pdown == m_act[34], {req, " phase/pdown"},
          64'({phase, pdown}), 64'(m_act[39:34]));
      chk(upd == 1'b1, "R5 upd high after commit", 64'(upd), 64'd1);
      @(negedge clk);
      chk(upd == 1'b0 && ftw == m_act[31:0], "R5 upd one cycle, R11 hold", 64'({upd, ftw}), 64'({1'b0, m_act[31:0]}));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_0001));
      model_reset();
      repeat (2) @(negedge clk);
      chk(ftw == 0 && phase == 0 && pdown == 0 && upd == 0, "R1 in reset", 64'({ftw, phase, pdown, upd}), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(ftw == 0 && phase == 0 && pdown == 0 && upd == 0, "R1 after reset", 64'({ftw, phase, pdown, upd}), 64'd0);

      // R2 R3: directed byte load, phase 5'b10101, power-down set, format 00
      wr_byte(8'b10101_1_00); wr_byte(8'h12); wr_byte(8'h34);
      wr_byte(8'h56); wr_byte(8'h78);
      chk(ftw == 0 && upd == 0, "R11 outputs hold while staging", 64'(ftw), 64'd0);
      commit_chk("R2 R3 R4 byte load");
      chk(ftw == 32'h12345678 && phase == 5'd21 && pdown, "R2 absolute value",
          64'({ftw, phase, pdown}), 64'({32'h12345678, 5'd21, 1'b1}));

      // R6: one byte after commit lands in the control byte, tuning word kept
      wr_byte(8'b00011_0_01);
      commit_chk("R6 pointer restart");
      chk(phase == 5'd3 && ftw == 32'h12345678, "R6 control rewritten only",
          64'({ftw, phase}), 64'({32'h12345678, 5'd3}));

      // R7: seven writes, last two ignored
      wr_byte(8'h08); wr_byte(8'hAA); wr_byte(8'hBB); wr_byte(8'hCC);
      wr_byte(8'hDD); wr_byte(8'hEE); wr_byte(8'hFF);
      commit_chk("R7 extra bytes ignored");
      chk(ftw == 32'hAABBCCDD, "R7 no wrap", 64'(ftw), 64'hAABBCCDD);

      // random byte-mode loads, format kept away from 2'b11
      for (int it = 0; it < 40; it++) begin
         int n;
         n = $urandom_range(0, 7);
         for (int k = 0; k < n; k++) begin
            logic [7:0] b;
            b = 8'($urandom());
            if (k == 0 && b[1:0] == 2'b11) b[1] = 1'b0;
            wr_byte(b);
         end
         commit_chk("R2 R4 random byte load");
      end

      // R12: reset in mid-load
      wr_byte(8'hF8); wr_byte(8'h11); wr_byte(8'h22);
      do_reset();
      chk(ftw == 0 && upd == 0, "R1 R12 outputs cleared", 64'(ftw), 64'd0);
      commit_chk("R12 staging cleared");
      chk(ftw == 0 && phase == 0 && !pdown, "R12 zero commit", 64'({ftw, phase, pdown}), 64'd0);
      wr_byte(8'b01110_0_00);
      commit_chk("R12 pointer cleared");
      chk(phase == 5'd14, "R12 first write is control", 64'(phase), 64'd14);

      // R8: enter bit mode
      wr_byte(8'b00000_0_11);
      commit_chk("R8 switch commit");
      chk(m_bitmode, "R8 model in bit mode", 64'(m_bitmode), 64'd1);

      // R9: directed 40-bit stream
      send_bits(40'hA5_DEADBEEF, 40);
      commit_chk("R9 bit load");
      chk(ftw == 32'hDEADBEEF && phase == 5'b10100 && pdown, "R9 absolute value",
          64'({ftw, phase, pdown}), 64'({32'hDEADBEEF, 5'b10100, 1'b1}));

      // R10: 45 bits, last five ignored
      send_bits(40'h3C_0F0F1234, 45);
      commit_chk("R10 extra bits ignored");
      chk(ftw == 32'h0F0F1234, "R10 no wrap", 64'(ftw), 64'h0F0F1234);

      // R8: control byte with format 00 does not leave bit mode
      send_bits(40'h00_00000001, 40);
      commit_chk("R8 sticky commit");
      send_bits(40'h48_CAFEF00D, 40);
      commit_chk("R8 still bit mode");
      chk(ftw == 32'hCAFEF00D, "R8 stream accepted", 64'(ftw), 64'hCAFEF00D);

      for (int it = 0; it < 20; it++) begin
         logic [39:0] w;
         w = {8'($urandom()), 32'($urandom())};
         send_bits(w, $urandom_range(0, 44));
         commit_chk("R9 random bit load");
      end

      // R1 R8: reset returns to byte mode
      do_reset();
      wr_byte(8'h90); wr_byte(8'h01); wr_byte(8'h02); wr_byte(8'h03); wr_byte(8'h04);
      commit_chk("R1 R8 byte mode after reset");
      chk(ftw == 32'h01020304 && phase == 5'd18, "R1 byte mode restored",
          64'({ftw, phase}), 64'({32'h01020304, 5'd18}));

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule